// File: doc/BRIEF.md
# Receive Frame Status Queue

This block keeps track of the received frames that sit in a receive byte buffer and shows the host a 16-bit status word for the oldest one. The receiving MAC side marks a frame's start, delivers its bytes one per cycle, and closes the frame with a 4-bit error code. The block counts the bytes it accepts and records the code with that count in a small ring of frame descriptors. The host drains the head frame one byte at a time, or drops it with one discard pulse.

Two admission limits protect the buffer. One is a cap on the number of complete frames held at once. The other is a byte-occupancy ceiling with hysteresis. While either limit is hit, a new frame start is refused. A frame that runs into the byte ceiling loses its excess bytes and is stored with the overrun code. A host read beyond the head frame's last byte, or a read with nothing queued, is a fatal adapter fault. Only a receive reset or the global reset clears that fault. The byte storage itself, the MAC and CRC logic are outside this block.

Top module: `rxq_status_queue`

## Requirements
- R1: With at least one complete frame queued, `status_word` is {1'b0, code[3:0], len[10:0]} for the head frame. Bit 15 is 0, bits 14..11 hold the stored code and bits 10..0 hold the number of bytes accepted for that frame.
- R2: With no complete frame queued, `status_word` has bit 15 set and bits 14..11 zero. Bits 10..0 hold the bytes accepted so far for the frame in progress, or 0 when none is in progress.
- R3: `status_full` is high exactly when `frame_count` equals MAX_FRAMES (default 8). A frame start in that state is refused: its bytes and its end are ignored. The flag drops after one frame leaves the queue.
- R4: `fifo_full` rises when the byte occupancy reaches FIFO_BYTES. It falls once the occupancy is at or below FIFO_BYTES-RESUME_GAP. Bytes that arrive while occupancy equals FIFO_BYTES are lost, and their frame is stored with code 4'b1000 (overrun). A frame start is refused while `fifo_full` is high.
- R5: A `rd_byte` with no complete frame queued, or after every byte of the head frame has been read, sets `adapter_fail`. The flag stays set until `rx_reset`. While it is set, reads and discards are ignored.
- R6: `discard_head` removes the head frame and frees its unread bytes. It does nothing when the queue is empty. It wins over a `rd_byte` in the same cycle, which is then ignored.
- R7: The read that takes the last byte of the head frame removes that frame, and the next frame becomes the head.
- R8: `receiving` is high from the cycle after an accepted `wr_sof` until the `wr_eof` that closes the frame. Bytes count from the cycle after the start.
- R9: `frame_ready` is high whenever at least one complete frame is queued.
- R10: `rx_reset` empties the queue, zeroes the occupancy, clears `fifo_full` and `adapter_fail`, and abandons any frame in progress.
- R11: When no bytes were lost, the stored code equals `wr_code` unchanged for every 4-bit value. Examples: 1011 runt, 1101 CRC, 1100 alignment, 1001 oversize, 0010 dribble, and all others meaning no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global reset |
| rx_reset | input | 1 | Receive reset pulse |
| discard_head | input | 1 | Drop the head frame |
| wr_sof | input | 1 | MAC frame start |
| wr_byte | input | 1 | MAC delivers one byte |
| wr_eof | input | 1 | MAC frame end |
| wr_code | input | 4 | Error code sampled with wr_eof |
| rd_byte | input | 1 | Host reads one byte of the head frame |
| status_word | output | 16 | Head frame status word |
| frame_count | output | CNT_W | Complete frames queued |
| frame_ready | output | 1 | At least one complete frame queued |
| receiving | output | 1 | A frame is being written |
| status_full | output | 1 | Frame cap reached |
| fifo_full | output | 1 | Byte occupancy ceiling flag |
| adapter_fail | output | 1 | Sticky host read-underrun fault |

## Verification
The hardest state to reach from the ports is a frame that overlaps the byte ceiling. The ceiling must be hit in the middle of a frame, then released by host reads one byte at a time across the hysteresis gap. The bench runs a small configuration with a 32-byte buffer. It first parks a 30-byte frame, then sends a 5-byte frame so that exactly three bytes are lost. It checks the flag one read before the release point and again at that point. Separate runs cover a full sweep of all sixteen codes, the eight-frame cap with a refused ninth frame, and a zero-length frame that makes the first read an underrun.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int LEN_W  = 11;
    localparam int CODE_W = 4;

    // code forced onto a frame that lost bytes at the buffer ceiling
    localparam logic [CODE_W-1:0] CODE_OVERRUN = 4'b1000;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  len;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  rxq_entry_t       push_entry,
    input  logic             pop,
    output rxq_entry_t       head,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } ring_st_t;

    ring_st_t   st_d, st_q;
    rxq_entry_t mem [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push) st_d.wp = bump(st_q.wp);
            if (pop)  st_d.rp = bump(st_q.rp);
            st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[st_q.wp] <= push_entry;
    end

    assign head  = mem[st_q.rp];
    assign count = st_q.cnt;
endmodule

// File: rtl/rxq_fill.sv
module rxq_fill #(
    parameter int BYTES = 2048,
    parameter int GAP   = 16,
    parameter int LVL_W = $clog2(BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             inc,
    input  logic [LVL_W-1:0] dec,
    output logic [LVL_W-1:0] level,
    output logic             full
);
    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             full;
    } fill_st_t;

    fill_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            st_d.level = st_q.level + LVL_W'(inc) - dec;
            if (st_d.level == LVL_W'(BYTES))
                st_d.full = 1'b1;
            else if (st_d.level <= LVL_W'(BYTES - GAP))
                st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;
    assign full  = st_q.full;
endmodule

// File: rtl/rxq_status_queue.sv
module rxq_status_queue
    import rxq_pkg::*;
#(
    parameter int MAX_FRAMES = 8,
    parameter int FIFO_BYTES = 2048,
    parameter int RESUME_GAP = 16,
    parameter int CNT_W      = $clog2(MAX_FRAMES + 1),
    parameter int LVL_W      = $clog2(FIFO_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_reset,
    input  logic              discard_head,
    input  logic              wr_sof,
    input  logic              wr_byte,
    input  logic              wr_eof,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              rd_byte,
    output logic [15:0]       status_word,
    output logic [CNT_W-1:0]  frame_count,
    output logic              frame_ready,
    output logic              receiving,
    output logic              status_full,
    output logic              fifo_full,
    output logic              adapter_fail
);
    typedef struct packed {
        logic             rcv;
        logic             lost;
        logic [LEN_W-1:0] wcnt;
        logic [LEN_W-1:0] rcnt;
        logic             fault;
    } ctl_st_t;

    ctl_st_t          ctl_d, ctl_q;
    rxq_entry_t       head, push_entry;
    logic [CNT_W-1:0] count;
    logic [LVL_W-1:0] level, dec;
    logic             fill_full, cnt_full, have_head;
    logic             sof_ok, byte_in, byte_ok, byte_lost, push;
    logic             disc_ok, rd_try, at_end, rd_ok, rd_bad, last, pop;
    logic [LEN_W-1:0] wcnt_n;

    always_comb begin
        cnt_full  = (count == CNT_W'(MAX_FRAMES));
        have_head = (count != '0);

        // write side
        sof_ok    = wr_sof && !ctl_q.rcv && !cnt_full && !fill_full;
        byte_in   = ctl_q.rcv && wr_byte;
        byte_ok   = byte_in && (level < LVL_W'(FIFO_BYTES))
                    && (ctl_q.wcnt != {LEN_W{1'b1}});
        byte_lost = byte_in && !byte_ok;
        push      = ctl_q.rcv && wr_eof;
        wcnt_n    = ctl_q.wcnt + LEN_W'(byte_ok);
        push_entry.code = (ctl_q.lost || byte_lost) ? CODE_OVERRUN : wr_code;
        push_entry.len  = wcnt_n;

        // host side, frozen while faulted
        disc_ok = discard_head && have_head && !ctl_q.fault;
        rd_try  = rd_byte && !discard_head && !ctl_q.fault;
        at_end  = !have_head || (ctl_q.rcnt == head.len);
        rd_ok   = rd_try && !at_end;
        rd_bad  = rd_try && at_end;
        last    = rd_ok && ((ctl_q.rcnt + LEN_W'(1)) == head.len);
        pop     = disc_ok || last;

        if (rd_ok)        dec = LVL_W'(1);
        else if (disc_ok) dec = LVL_W'(head.len - ctl_q.rcnt);
        else              dec = '0;

        ctl_d = ctl_q;
        if (sof_ok) begin
            ctl_d.rcv  = 1'b1;
            ctl_d.wcnt = '0;
            ctl_d.lost = 1'b0;
        end
        if (byte_in) begin
            ctl_d.wcnt = wcnt_n;
            ctl_d.lost = ctl_q.lost || byte_lost;
        end
        if (push) begin
            ctl_d.rcv  = 1'b0;
            ctl_d.wcnt = '0;
            ctl_d.lost = 1'b0;
        end
        if (pop)        ctl_d.rcnt = '0;
        else if (rd_ok) ctl_d.rcnt = ctl_q.rcnt + LEN_W'(1);
        if (rd_bad)     ctl_d.fault = 1'b1;
        if (rx_reset)   ctl_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rxq_ring #(.DEPTH(MAX_FRAMES), .CNT_W(CNT_W)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (rx_reset),
        .push       (push),
        .push_entry (push_entry),
        .pop        (pop),
        .head       (head),
        .count      (count)
    );

    rxq_fill #(.BYTES(FIFO_BYTES), .GAP(RESUME_GAP), .LVL_W(LVL_W)) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_reset),
        .inc   (byte_ok),
        .dec   (dec),
        .level (level),
        .full  (fill_full)
    );

    assign status_word  = have_head ? {1'b0, head.code, head.len}
                                    : {1'b1, {CODE_W{1'b0}}, ctl_q.wcnt};
    assign frame_count  = count;
    assign frame_ready  = have_head;
    assign receiving    = ctl_q.rcv;
    assign status_full  = cnt_full;
    assign fifo_full    = fill_full;
    assign adapter_fail = ctl_q.fault;
endmodule

// File: rtl/rxq_status_queue_chk.sv
module rxq_status_queue_chk #(
    parameter int MAX_FRAMES = 8,
    parameter int CNT_W      = $clog2(MAX_FRAMES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_reset,
    input logic             wr_sof,
    input logic [CNT_W-1:0] frame_count,
    input logic             receiving,
    input logic             status_full,
    input logic             fifo_full,
    input logic             adapter_fail
);
    a_r3_cap: assert property (@(posedge clk) disable iff (!rst_n)
        int'(frame_count) <= MAX_FRAMES);

    a_r3_refuse_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (status_full && wr_sof && !receiving) |=> !receiving);

    a_r4_refuse_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && wr_sof && !receiving) |=> !receiving);

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (adapter_fail && !rx_reset) |=> adapter_fail);

    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_reset |=> ((int'(frame_count) <= int'($past(frame_count)) + 1)
                    && (int'(frame_count) + 1 >= int'($past(frame_count)))));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> (frame_count == '0 && !adapter_fail && !fifo_full && !receiving));
endmodule

bind rxq_status_queue rxq_status_queue_chk #(
    .MAX_FRAMES (MAX_FRAMES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_reset     (rx_reset),
    .wr_sof       (wr_sof),
    .frame_count  (frame_count),
    .receiving    (receiving),
    .status_full  (status_full),
    .fifo_full    (fifo_full),
    .adapter_fail (adapter_fail)
);

// File: tb/sim_rxq_status_queue.sv
module sim_rxq_status_queue;
    localparam int CLK_PERIOD = 10;
    localparam int MAXF       = 8;
    localparam int BYTES      = 32;
    localparam int GAP        = 4;
    localparam int CW         = $clog2(MAXF + 1);
    localparam int WATCHDOG   = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_reset = 1'b0, discard_head = 1'b0;
    logic          wr_sof = 1'b0, wr_byte = 1'b0, wr_eof = 1'b0, rd_byte = 1'b0;
    logic [3:0]    wr_code = '0;
    logic [15:0]   status_word;
    logic [CW-1:0] frame_count;
    logic          frame_ready, receiving, status_full, fifo_full, adapter_fail;

    int  nchk = 0, nfail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_status_queue #(.MAX_FRAMES(MAXF), .FIFO_BYTES(BYTES), .RESUME_GAP(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .discard_head(discard_head),
        .wr_sof(wr_sof), .wr_byte(wr_byte), .wr_eof(wr_eof), .wr_code(wr_code),
        .rd_byte(rd_byte), .status_word(status_word), .frame_count(frame_count),
        .frame_ready(frame_ready), .receiving(receiving), .status_full(status_full),
        .fifo_full(fifo_full), .adapter_fail(adapter_fail)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic sof();
        wr_sof = 1'b1; cyc(); wr_sof = 1'b0;
    endtask

    task automatic bytes_in(input int n);
        for (int i = 0; i < n; i++) begin wr_byte = 1'b1; cyc(); end
        wr_byte = 1'b0;
    endtask

    task automatic eof(input logic [3:0] code);
        wr_eof = 1'b1; wr_code = code; cyc(); wr_eof = 1'b0;
    endtask

    task automatic frame(input int n, input logic [3:0] code);
        sof(); bytes_in(n); eof(code);
    endtask

    task automatic reads(input int n);
        for (int i = 0; i < n; i++) begin rd_byte = 1'b1; cyc(); end
        rd_byte = 1'b0;
    endtask

    task automatic discard();
        discard_head = 1'b1; cyc(); discard_head = 1'b0;
    endtask

    task automatic rxrst();
        rx_reset = 1'b1; cyc(); rx_reset = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // reset state
        chk("R2 reset word", status_word, 16'h8000);
        chk("R9 reset ready", frame_ready, 0);
        chk("R5 reset fault", adapter_fail, 0);
        chk("R4 reset full", fifo_full, 0);

        // frame in progress, then completion
        sof();
        chk("R8 receiving after sof", receiving, 1);
        bytes_in(3);
        chk("R2 partial count", status_word, 16'h8003);
        eof(4'b1101);
        chk("R8 receiving after eof", receiving, 0);
        chk("R1 head word crc", status_word, 16'h6803);
        chk("R9 ready", frame_ready, 1);
        reads(2);
        chk("R7 not yet advanced", frame_count, 1);
        reads(1);
        chk("R7 advanced", frame_count, 0);
        chk("R2 empty word", status_word, 16'h8000);

        // sweep all codes, length code+1
        for (int c = 0; c < 16; c++) begin
            frame(c + 1, 4'(c));
            chk("R11 code sweep", status_word, (c << 11) | (c + 1));
            reads(c + 1);
            chk("R7 sweep drained", frame_count, 0);
            chk("R5 sweep no fault", adapter_fail, 0);
        end

        // frame cap
        for (int i = 0; i < MAXF; i++) frame(2, 4'(i));
        chk("R3 count at cap", frame_count, MAXF);
        chk("R3 cap flag", status_full, 1);
        sof();
        chk("R3 sof refused", receiving, 0);
        bytes_in(2); eof(4'hF);
        chk("R3 refused frame not queued", frame_count, MAXF);
        discard();
        chk("R6 discard count", frame_count, MAXF - 1);
        chk("R3 cap cleared", status_full, 0);
        chk("R6 next head", status_word, 16'h0802);
        rxrst();
        chk("R10 queue empty", frame_count, 0);
        chk("R10 word", status_word, 16'h8000);

        // byte ceiling
        frame(30, 4'b0000);
        sof(); bytes_in(2);
        chk("R4 full reached", fifo_full, 1);
        bytes_in(3); eof(4'b0010);
        chk("R4 count", frame_count, 2);
        sof();
        chk("R4 sof refused", receiving, 0);
        reads(3);
        chk("R4 full held", fifo_full, 1);
        reads(1);
        chk("R4 full released", fifo_full, 0);
        reads(26);
        chk("R4 overrun entry", status_word, 16'h4002);
        reads(2);
        chk("R7 drained", frame_count, 0);

        // underrun
        reads(1);
        chk("R5 empty read fault", adapter_fail, 1);
        frame(3, 4'b0000);
        reads(1);
        discard();
        chk("R5 host frozen", frame_count, 1);
        chk("R5 head untouched", status_word, 16'h0003);
        rxrst();
        chk("R10 fault cleared", adapter_fail, 0);
        sof(); eof(4'b0000);
        chk("R1 zero length", status_word, 16'h0000);
        reads(1);
        chk("R5 past end fault", adapter_fail, 1);
        rxrst();

        // discard corner cases
        discard();
        chk("R6 empty discard", adapter_fail, 0);
        frame(4, 4'b0000);
        discard_head = 1'b1; rd_byte = 1'b1; cyc();
        discard_head = 1'b0; rd_byte = 1'b0;
        chk("R6 priority count", frame_count, 0);
        chk("R6 priority no fault", adapter_fail, 0);
        frame(30, 4'b0000);
        reads(1);
        discard();
        frame(31, 4'b0000);
        chk("R6 bytes freed", fifo_full, 0);
        chk("R6 new head", status_word, 16'h001F);
        rxrst();

        // reset mid-frame
        sof(); bytes_in(2);
        rxrst();
        chk("R10 abandon", receiving, 0);
        chk("R10 abandon word", status_word, 16'h8000);
        eof(4'b0000);
        chk("R10 stray eof", frame_count, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule